// File: doc/BRIEF.md
# Multi-Channel Receiver Sync Controller

This block turns two write-only host command registers into per-channel start and hop strobes for a four-channel digital receiver. A host write to the software-sync address fires a sync event at once on every channel that selects one of the trigger bits set in that write. A write to the pin-sync address arms channels so they respond to an external, asynchronous sync pin. Each event can ask for a channel start, a hop (an NCO frequency update), or both.

Each channel has its own 2-bit source selector. The selector picks which of the four trigger or enable bits that channel follows, so channels can share one source, work in pairs, or each have their own. The pin path has an optional first-pulse-only mode. In that mode each channel acts on the first detected pin edge and then ignores later edges until the pin-sync register is written again. The selectors come from a per-channel configuration held elsewhere in the receiver. The NCO, the filters and the host bus decoding are not part of this block.

Top module: `rx_sync_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, all `start_o` and `hop_o` bits are 0. The stored pin-sync register resets to 0, so a pin edge with no prior pin-sync write produces no pulse.
- R2: A write to address 5 (`wr_en`=1, `wr_addr`=5) with data bit 4 set makes `start_o[c]` high for exactly the one cycle after the write edge, for every channel c whose selected trigger bit in data bits 3..0 is set.
- R3: A write to address 5 with data bit 5 set makes `hop_o[c]` high for exactly one cycle on the same channels. When bits 4 and 5 are both set, the start and hop pulses fire in the same cycle.
- R4: Channel c's selector is `chan_sel[2c+1:2c]`, with value k picking bit k of the trigger or enable nibble. Any mapping is allowed, including all channels on one bit.
- R5: The sync pin passes through two synchronizer flops and a rising-edge detector. A pin first sampled high at clock edge n produces its pulses in the cycle after edge n+2. The pulses appear only on channels whose selected enable bit (bits 3..0 of the address-4 register) is set.
- R6: For pin events, bit 4 of the address-4 register enables the start pulse and bit 5 enables the hop pulse. With neither bit set, no pulse is produced.
- R7: With bit 6 of the address-4 register clear, every pin rising edge acts. With bit 6 set, each channel acts only on its first pin edge.
- R8: Any write to address 4 clears every channel's first-pulse latch, so the next pin edge acts again.
- R9: Writes to any address other than 4 or 5 have no effect on the outputs or on the pin-sync configuration. A pin held high produces one event, not one per cycle.
- R10: When a software event and a pin event reach the same channel in the same cycle, the channel's outputs are the OR of the two requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address (4 = pin sync, 5 = software sync) |
| wr_data | input | 8 | Host write data |
| chan_sel | input | 8 | Per-channel 2-bit source selectors, channel 0 in bits 1..0 |
| sync_pin | input | 1 | Asynchronous external sync pin |
| start_o | output | 4 | Per-channel one-cycle start pulse |
| hop_o | output | 4 | Per-channel one-cycle NCO frequency update pulse |

## Verification
On every cycle the assertions check several things. Any start or hop pulse must trace back to a software write or a detected pin edge in the previous cycle. The edge detector never reports two edges back to back. A latched channel in first-pulse mode stays silent on later pin edges. A pin-sync write clears every latch, and writes to unrelated addresses leave the outputs quiet. Only the bench's scenarios can show the mapping itself: which channels pulse for each trigger nibble under each selector arrangement, the three-edge pin latency, and the OR-ing of simultaneous software and pin requests. The bench sweeps all trigger nibbles, action bits and once settings for this.

// File: rtl/rx_sync_pkg.sv
// Package: shared constants and types for the receiver sync controller.
// Assumes a host data bus of at least 7 bits and four sync sources.
package rx_sync_pkg;
    localparam int NSRC      = 4;               // sync trigger/enable bits
    localparam int SEL_W     = $clog2(NSRC);    // selector width per channel
    localparam int DATA_W    = 8;               // host data width
    localparam int ADDR_W    = 3;               // host address width
    localparam int BIT_START = 4;               // action bit: start channel
    localparam int BIT_HOP   = 5;               // action bit: NCO update
    localparam int BIT_ONCE  = 6;               // pin register: first pulse only

    localparam logic [ADDR_W-1:0] ADDR_PIN = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ADDR_SW  = ADDR_W'(5);

    // Stored pin-sync configuration
    typedef struct packed {
        logic            once;
        logic            hop;
        logic            start;
        logic [NSRC-1:0] en;
    } pin_cfg_t;

    // Software command decoded from a write
    typedef struct packed {
        logic            start;
        logic            hop;
        logic [NSRC-1:0] trig;
    } sw_cmd_t;
endpackage

// File: rtl/rx_sync_pin_front.sv
// Pin front end: brings the asynchronous sync pin into the clock domain
// through a chain of STAGES flops and flags a rising edge for one cycle.
// Assumes the pin stays at each level for more than STAGES+1 clocks.
module rx_sync_pin_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Purpose: shift the pin through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_async};
    end

    // Purpose: remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Purpose: one-cycle flag on a low-to-high synchronized transition
    always_comb pin_rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rx_sync_regs.sv
// Register decode: stores the write-only pin-sync configuration and
// presents a software-sync write as a single-cycle command. The software
// register is a pure command, so nothing of it is kept past the write.
module rx_sync_regs
    import rx_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sw_hit,
    output sw_cmd_t           sw_cmd,
    output logic              pin_wr,
    output pin_cfg_t          pin_cfg
);
    logic unused_bits;

    // Purpose: address decode of the two command locations
    always_comb begin
        sw_hit = wr_en && (wr_addr == ADDR_SW);
        pin_wr = wr_en && (wr_addr == ADDR_PIN);
    end

    // Purpose: slice the software command fields straight from the bus
    always_comb begin
        sw_cmd.trig  = wr_data[NSRC-1:0];
        sw_cmd.start = wr_data[BIT_START];
        sw_cmd.hop   = wr_data[BIT_HOP];
    end

    // Purpose: hold the pin-sync configuration between writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_cfg <= '0;
        end else if (pin_wr) begin
            pin_cfg.en    <= wr_data[NSRC-1:0];
            pin_cfg.start <= wr_data[BIT_START];
            pin_cfg.hop   <= wr_data[BIT_HOP];
            pin_cfg.once  <= wr_data[BIT_ONCE];
        end
    end

    // Purpose: mark data bits with no function in these registers
    always_comb unused_bits = ^wr_data[DATA_W-1:BIT_ONCE+1];
endmodule

// File: rtl/rx_sync_chan.sv
// Per-channel sync slice: picks its source bit with the selector, merges
// software and pin requests, and registers one-cycle start/hop pulses.
// Keeps a first-pulse latch used when the pin register's once bit is set.
module rx_sync_chan
    import rx_sync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             sw_hit,
    input  sw_cmd_t          sw_cmd,
    input  logic             pin_rise,
    input  logic             pin_wr,
    input  pin_cfg_t         pin_cfg,
    output logic             start_o,
    output logic             hop_o,
    output logic             fired_o
);
    logic sw_go;
    logic pin_go;
    logic fired_q;

    // Purpose: qualify each event source with this channel's selected bit
    always_comb begin
        sw_go  = sw_hit & sw_cmd.trig[sel];
        pin_go = pin_rise & pin_cfg.en[sel] & ~(pin_cfg.once & fired_q);
    end

    // Purpose: register the merged one-cycle start and hop pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= 1'b0;
            hop_o   <= 1'b0;
        end else begin
            start_o <= (sw_go & sw_cmd.start) | (pin_go & pin_cfg.start);
            hop_o   <= (sw_go & sw_cmd.hop)   | (pin_go & pin_cfg.hop);
        end
    end

    // Purpose: first-pulse latch, cleared by any pin-register write
    always_ff @(posedge clk) begin
        if (!rst_n)      fired_q <= 1'b0;
        else if (pin_wr) fired_q <= 1'b0;
        else if (pin_go) fired_q <= 1'b1;
    end

    always_comb fired_o = fired_q;
endmodule

// File: rtl/rx_sync_ctrl.sv
// Top: multi-channel sync controller. Decodes host writes, synchronizes
// the sync pin and fans both out to NCH channel slices.
// Assumes selectors are static while events are in flight.
module rx_sync_ctrl
    import rx_sync_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int PIN_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NCH*SEL_W-1:0] chan_sel,
    input  logic                 sync_pin,
    output logic [NCH-1:0]       start_o,
    output logic [NCH-1:0]       hop_o
);
    logic     sw_hit;
    sw_cmd_t  sw_cmd;
    logic     pin_wr;
    pin_cfg_t pin_cfg;
    logic     pin_rise;
    logic [NCH-1:0] fired_vec;

    rx_sync_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sw_hit  (sw_hit),
        .sw_cmd  (sw_cmd),
        .pin_wr  (pin_wr),
        .pin_cfg (pin_cfg)
    );

    rx_sync_pin_front #(.STAGES(PIN_STAGES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (sync_pin),
        .pin_rise  (pin_rise)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        rx_sync_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (chan_sel[c*SEL_W +: SEL_W]),
            .sw_hit   (sw_hit),
            .sw_cmd   (sw_cmd),
            .pin_rise (pin_rise),
            .pin_wr   (pin_wr),
            .pin_cfg  (pin_cfg),
            .start_o  (start_o[c]),
            .hop_o    (hop_o[c]),
            .fired_o  (fired_vec[c])
        );
    end
endmodule

// File: rtl/rx_sync_ctrl_chk.sv
// Checker: temporal properties of the sync controller, bound to the top.
module rx_sync_ctrl_chk
    import rx_sync_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              sw_hit,
    input logic              pin_wr,
    input logic              pin_rise,
    input logic              pin_once,
    input logic [NCH-1:0]    fired,
    input logic [NCH-1:0]    start_o,
    input logic [NCH-1:0]    hop_o
);
    // R2: a start pulse needs a software write or pin edge one cycle earlier
    a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o != '0) |-> $past(sw_hit || pin_rise));

    // R3: a hop pulse needs a software write or pin edge one cycle earlier
    a_r3_hop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (hop_o != '0) |-> $past(sw_hit || pin_rise));

    // R9: a held pin yields a single edge flag
    a_r9_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);

    // R8: a pin-register write clears every first-pulse latch
    a_r8_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pin_wr |=> (fired == '0));

    // R9: writes to other addresses with no pin edge leave outputs quiet
    a_r9_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_PIN && wr_addr != ADDR_SW && !pin_rise)
        |=> (start_o == '0 && hop_o == '0));

    // R7: a latched channel in once mode ignores later pin edges
    for (genvar c = 0; c < NCH; c++) begin : g_once
        a_r7_once_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            $past(fired[c] && pin_once && pin_rise && !sw_hit && !pin_wr)
            |-> (!start_o[c] && !hop_o[c]));
    end
endmodule

bind rx_sync_ctrl rx_sync_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .sw_hit   (sw_hit),
    .pin_wr   (pin_wr),
    .pin_rise (pin_rise),
    .pin_once (pin_cfg.once),
    .fired    (fired_vec),
    .start_o  (start_o),
    .hop_o    (hop_o)
);

// File: tb/tb_rx_sync_ctrl.sv
module tb_rx_sync_ctrl;
    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] chan_sel = 8'b11_10_01_00;
    logic       sync_pin = 1'b0;
    logic [3:0] start_o;
    logic [3:0] hop_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rx_sync_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .chan_sel(chan_sel), .sync_pin(sync_pin),
        .start_o(start_o), .hop_o(hop_o)
    );

    // Channels whose selected bit is set in the nibble
    function automatic logic [3:0] pick(input logic [3:0] nib, input logic [7:0] sel);
        logic [3:0] m;
        for (int c = 0; c < NCH; c++) m[c] = nib[sel[c*2 +: 2]];
        return m;
    endfunction

    task automatic check(input logic [3:0] act_s, input logic [3:0] act_h,
                         input logic [3:0] exp_s, input logic [3:0] exp_h,
                         input string req);
        checks++;
        if (act_s !== exp_s || act_h !== exp_h) begin
            errors++;
            $display("FAIL %s start=%b hop=%b expected start=%b hop=%b",
                     req, act_s, act_h, exp_s, exp_h);
        end
    endtask

    // Write on one edge; returns at the negedge after that edge
    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Pulse the pin, return the outputs in the pulse cycle
    task automatic pin_pulse(output logic [3:0] s, output logic [3:0] h, input string req);
        @(negedge clk);
        sync_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(start_o, hop_o, 4'b0, 4'b0, req);     // not yet
        @(negedge clk);
        s = start_o; h = hop_o;
        sync_pin = 1'b0;
        @(negedge clk);
        check(start_o, hop_o, 4'b0, 4'b0, req);     // single cycle
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] s, h, es, eh;
        logic [7:0] sels [4];
        sels[0] = 8'b11_10_01_00;   // independent
        sels[1] = 8'b00_00_00_00;   // all on bit 0
        sels[2] = 8'b10_10_00_00;   // pairs
        sels[3] = 8'b00_01_10_11;   // reversed

        // R1: reset state
        repeat (3) @(negedge clk);
        check(start_o, hop_o, 4'b0, 4'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(start_o, hop_o, 4'b0, 4'b0, "R1 after reset");
        pin_pulse(s, h, "R1");
        check(s, h, 4'b0, 4'b0, "R1 pin with reset config");

        // R2 R3 R4: software sweep over selector maps, nibbles and action bits
        for (int k = 0; k < 4; k++) begin
            chan_sel = sels[k];
            for (int v = 0; v < 64; v++) begin
                host_write(3'd5, 8'(v));
                es = v[4] ? pick(v[3:0], chan_sel) : 4'b0;
                eh = v[5] ? pick(v[3:0], chan_sel) : 4'b0;
                check(start_o, hop_o, es, eh, "R2 R3 R4 sw pulse");
                @(negedge clk);
                check(start_o, hop_o, 4'b0, 4'b0, "R2 sw single cycle");
            end
        end

        // R5 R6 R7: pin sweep over enables, actions and once bit
        for (int k = 0; k < 2; k++) begin
            chan_sel = sels[k*2];
            for (int v = 0; v < 128; v++) begin
                host_write(3'd4, 8'(v));
                es = v[4] ? pick(v[3:0], chan_sel) : 4'b0;
                eh = v[5] ? pick(v[3:0], chan_sel) : 4'b0;
                pin_pulse(s, h, "R5");
                check(s, h, es, eh, "R5 R6 pin first edge");
                pin_pulse(s, h, "R7");
                if (v[6]) check(s, h, 4'b0, 4'b0, "R7 once blocks second edge");
                else      check(s, h, es, eh, "R7 repeat edge acts");
            end
        end

        // R8: rewrite clears latch
        chan_sel = sels[0];
        host_write(3'd4, 8'h7F);
        pin_pulse(s, h, "R8");
        check(s, h, 4'hF, 4'hF, "R8 first edge");
        pin_pulse(s, h, "R8");
        check(s, h, 4'h0, 4'h0, "R8 latched");
        host_write(3'd4, 8'h7F);
        pin_pulse(s, h, "R8");
        check(s, h, 4'hF, 4'hF, "R8 after rewrite");

        // R9: other addresses ignored, pin config kept
        host_write(3'd4, 8'h13);
        for (int a = 0; a < 8; a++) begin
            if (a == 4 || a == 5) continue;
            host_write(3'(a), 8'h7F);
            check(start_o, hop_o, 4'b0, 4'b0, "R9 other address quiet");
        end
        pin_pulse(s, h, "R9");
        check(s, h, 4'b0011, 4'b0, "R9 pin config unchanged");

        // R9: held pin gives one event
        @(negedge clk);
        sync_pin = 1'b1;
        repeat (3) @(negedge clk);
        check(start_o, hop_o, 4'b0011, 4'b0, "R9 held pin event");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(start_o, hop_o, 4'b0, 4'b0, "R9 held pin no repeat");
        end
        sync_pin = 1'b0;
        repeat (4) @(negedge clk);

        // R10: software and pin events in the same cycle merge
        host_write(3'd4, 8'h11);              // ch0 start on pin
        @(negedge clk);
        sync_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);                        // edge flag now high
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h32;  // ch1 start+hop
        @(negedge clk);
        wr_en = 1'b0;
        check(start_o, hop_o, 4'b0011, 4'b0010, "R10 merged requests");
        sync_pin = 1'b0;
        @(negedge clk);
        check(start_o, hop_o, 4'b0, 4'b0, "R10 single cycle");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule